// File: doc/BRIEF.md
# I2C bus recovery sequencer

This block frees an I2C bus that a slave holds hung by keeping SDA low. Software reads a command/status word that carries the synchronized SCL and SDA levels and a bus-busy flag. When that word shows a busy bus before a new transfer, software writes a recovery command. The sequencer then clocks SCL, one pulse at a time, until the slave lets go of SDA. It issues at most eight pulses.

Once SDA is seen high, the sequencer places a STOP condition on the bus and sets a sticky completion flag, which also drives the interrupt line. If SDA is still low after the eighth pulse, it sends no STOP and still reports completion, so software sees the failure in the SDA status bit. Pulse phases are paced by a one-cycle timing tick from outside. Both lines are driven through open-drain enables, where an enable of 1 pulls the line low.

Top module: `i2c_bus_unhang`

## Requirements
- R1: Bit 18 of `cmd_status` shows the SCL level and bit 17 shows the SDA level. Each is taken through a two-flop synchronizer, so a change on the pin shows in the status word after two rising clock edges.
- R2: Bit 16 of `cmd_status` (bus busy) is 1 while a recovery is running or while either synchronized line is low, and 0 otherwise. All other bits of `cmd_status` read 0.
- R3: A write on `cmd_we` with bit 11 of `cmd_wdata` set starts a recovery only when none is running. A write with bit 11 clear, or a write made during a recovery, has no effect on the lines or the pulse count. While idle, both enables stay 0.
- R4: A recovery gives between 1 and 8 SCL pulses. After the first one, each low phase and each high phase lasts from one `tick` to the next. SDA is checked at the end of each high phase, and pulsing stops as soon as SDA is high there.
- R5: After SDA is released, the STOP is generated in this order: SCL is pulled low, then SDA is pulled low, then SCL is released, then SDA is released while SCL is high. Each step lasts one tick interval. SDA is never pulled low while SCL is released, which would form a START.
- R6: If SDA is still low at the end of the eighth high phase, no STOP is driven and the done flag is still set. `cmd_status` bit 17 then reads 0.
- R7: Bit 13 of `irq_status` is set when a recovery finishes, and `irq` equals it. The bit stays set until `sts_we` is written with bit 13 of `sts_wdata` at 1. Writing 0 to bit 13 leaves it set.
- R8: While reset is asserted, `scl_oe`, `sda_oe` and `irq` are 0, `irq_status` is 0, and `cmd_status` is 32'h0006_0000 (both lines read high, not busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle pulse that paces each SCL phase |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word; bit 11 requests a recovery |
| sts_we | input | 1 | Write strobe for the interrupt status word |
| sts_wdata | input | 32 | Write-one-to-clear mask; bit 13 clears the done flag |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| cmd_status | output | 32 | Line levels (bits 18, 17) and bus busy (bit 16) |
| irq_status | output | 32 | Done flag in bit 13 |
| irq | output | 1 | Completion interrupt, equal to the done flag |

## Verification
Line levels reach the status word two edges after a pin change, so the bench changes a pin on a falling edge and reads the status two falling edges later. A recovery command is registered on the next rising edge, and the line enables change on the same edge as the sequencer state. The bench therefore reads pulses, STOP order and phase widths from falling-edge samples of the enables and counts widths in clock cycles between those samples. The done flag comes one edge after the final state, so the bench polls `irq` on falling edges with a bound and then checks the line status and the pulse and STOP counts in that same sample.

// File: rtl/i2c_unhang_pkg.sv
package i2c_unhang_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_PLS_LO = 3'd1,
    SQ_PLS_HI = 3'd2,
    SQ_STP_A  = 3'd3,
    SQ_STP_B  = 3'd4,
    SQ_STP_C  = 3'd5,
    SQ_STP_D  = 3'd6,
    SQ_FIN    = 3'd7
  } seq_state_e;

  localparam int unsigned BIT_SCL_LVL = 18;
  localparam int unsigned BIT_SDA_LVL = 17;
  localparam int unsigned BIT_BUSY    = 16;
  localparam int unsigned BIT_RECOVER = 11;
  localparam int unsigned BIT_DONE    = 13;

endpackage

// File: rtl/unhang_rst_sync.sv
module unhang_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/unhang_line_sync.sv
module unhang_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= RST_VAL;
        else        pipe_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/unhang_seq.sv
module unhang_seq
  import i2c_unhang_pkg::*;
#(
  parameter int MAX_PULSES = 8,
  localparam int CNT_W = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic sda_hi,
  output logic run,
  output logic finish,
  output logic scl_oe,
  output logic sda_oe
);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;
  logic scl_oe_q, scl_oe_d;
  logic sda_oe_q, sda_oe_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_PLS_LO;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SQ_PLS_LO: if (tick) state_d = SQ_PLS_HI;
      SQ_PLS_HI: begin
        if (tick) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
          if (sda_hi)                                state_d = SQ_STP_A;
          else if (cnt_q == CNT_W'(MAX_PULSES - 1)) state_d = SQ_FIN;
          else                                       state_d = SQ_PLS_LO;
        end
      end
      SQ_STP_A: if (tick) state_d = SQ_STP_B;
      SQ_STP_B: if (tick) state_d = SQ_STP_C;
      SQ_STP_C: if (tick) state_d = SQ_STP_D;
      SQ_STP_D: if (tick) state_d = SQ_FIN;
      SQ_FIN:   state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  // line enables follow the next state so they are glitch-free flops
  always_comb begin
    scl_oe_d = (state_d == SQ_PLS_LO) || (state_d == SQ_STP_A) || (state_d == SQ_STP_B);
    sda_oe_d = (state_d == SQ_STP_B) || (state_d == SQ_STP_C);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign run    = (state_q != SQ_IDLE);
  assign finish = (state_q == SQ_FIN);
  assign scl_oe = scl_oe_q;
  assign sda_oe = sda_oe_q;

endmodule

// File: rtl/unhang_regs.sv
module unhang_regs
  import i2c_unhang_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] sts_wdata,
  input  logic              run,
  input  logic              finish,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  output logic              start,
  output logic [DATA_W-1:0] cmd_status,
  output logic [DATA_W-1:0] irq_status,
  output logic              irq
);

  logic done_q, done_d, done_en;
  logic clr_req;
  logic unused_wdata;

  assign unused_wdata = ^{cmd_wdata, sts_wdata};

  assign start   = cmd_we && cmd_wdata[BIT_RECOVER] && !run;
  assign clr_req = sts_we && sts_wdata[BIT_DONE];

  // set wins over clear in the same cycle
  always_comb begin
    done_en = finish || clr_req;
    done_d  = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  always_comb begin
    cmd_status              = '0;
    cmd_status[BIT_SCL_LVL] = scl_lvl;
    cmd_status[BIT_SDA_LVL] = sda_lvl;
    cmd_status[BIT_BUSY]    = run || !scl_lvl || !sda_lvl;
    irq_status              = '0;
    irq_status[BIT_DONE]    = done_q;
  end

  assign irq = done_q;

endmodule

// File: rtl/i2c_bus_unhang.sv
module i2c_bus_unhang #(
  parameter int DATA_W      = 32,
  parameter int MAX_PULSES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] sts_wdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] cmd_status,
  output logic [DATA_W-1:0] irq_status,
  output logic              irq
);

  logic rst_n_s;
  logic scl_lvl, sda_lvl;
  logic seq_run, seq_finish, seq_start;

  unhang_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  unhang_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_lvl)
  );

  unhang_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_lvl)
  );

  unhang_seq #(.MAX_PULSES(MAX_PULSES)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .start(seq_start),
    .sda_hi(sda_lvl), .run(seq_run), .finish(seq_finish),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  unhang_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .run(seq_run), .finish(seq_finish),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .start(seq_start), .cmd_status(cmd_status),
    .irq_status(irq_status), .irq(irq)
  );

endmodule

// File: rtl/i2c_bus_unhang_chk.sv
module i2c_bus_unhang_chk #(
  parameter int DATA_W     = 32,
  parameter int MAX_PULSES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              irq,
  input logic              sts_we,
  input logic [DATA_W-1:0] sts_wdata
);

  localparam int CW = $clog2(MAX_PULSES + 2);

  logic [CW-1:0] pulse_cnt;
  logic          scl_oe_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt   <= '0;
      scl_oe_prev <= 1'b0;
    end else begin
      scl_oe_prev <= scl_oe;
      if (!run)                                   pulse_cnt <= '0;
      else if (scl_oe_prev && !scl_oe && !sda_oe) pulse_cnt <= pulse_cnt + 1'b1;
    end
  end

  AST_NO_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_oe) else $error("SDA pulled while SCL released"); // R5

  AST_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_oe) else $error("SDA released while SCL held"); // R5

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!scl_oe && !sda_oe)) else $error("line driven while idle"); // R3

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CW'(MAX_PULSES)) else $error("too many pulses"); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(sts_we && sts_wdata[13])) |=> irq) else $error("done lost"); // R7

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(run)) else $error("done without recovery"); // R7

endmodule

bind i2c_bus_unhang i2c_bus_unhang_chk #(.DATA_W(DATA_W), .MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(seq_run), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .sts_we(sts_we), .sts_wdata(sts_wdata)
);

// File: tb/tb_i2c_bus_unhang.sv
module tb_i2c_bus_unhang;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;

  // {release_after[15:8], expected pulses[7:4], expected stops[3:0]}
  localparam logic [15:0] VEC [0:6] = '{
    {8'd0,  4'd1, 4'd1},
    {8'd1,  4'd1, 4'd1},
    {8'd3,  4'd3, 4'd1},
    {8'd5,  4'd5, 4'd1},
    {8'd8,  4'd8, 4'd1},
    {8'd9,  4'd8, 4'd0},
    {8'd12, 4'd8, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        cmd_we, sts_we;
  logic [31:0] cmd_wdata, sts_wdata;
  logic        scl_in, sda_in, scl_oe, sda_oe, irq;
  logic [31:0] cmd_status, irq_status;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int slave_k = 0;
  int slave_seen = 0;
  int pulses_seen = 0;
  int stops_seen = 0;
  int starts_bad = 0;
  int fall_cyc = 0;
  int hi_w = -1;
  int oe_cycles = 0;
  logic force_scl_low = 1'b0;
  logic force_sda_low = 1'b0;
  logic prev_scl = 1'b0;
  logic prev_sda = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign scl_in = !scl_oe && !force_scl_low;
  assign sda_in = !sda_oe && !force_sda_low && !(slave_seen < slave_k);

  i2c_bus_unhang dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cmd_status(cmd_status), .irq_status(irq_status), .irq(irq)
  );

  // bus monitor and tick source, all on the falling edge
  always @(negedge clk) begin
    cyc  <= cyc + 1;
    tick <= ((cyc % TICK_DIV) == TICK_DIV - 1);
    prev_scl <= scl_oe;
    prev_sda <= sda_oe;
    if (scl_oe || sda_oe) oe_cycles <= oe_cycles + 1;
    if (prev_scl && !scl_oe && !sda_oe) begin
      pulses_seen <= pulses_seen + 1;
      slave_seen  <= slave_seen + 1;
      fall_cyc    <= cyc;
    end
    if (!prev_scl && scl_oe && !sda_oe && hi_w < 0 && pulses_seen > 0)
      hi_w <= cyc - fall_cyc;
    if (prev_sda && !sda_oe && !scl_oe) stops_seen <= stops_seen + 1;
    if (!prev_sda && sda_oe && !scl_oe) starts_bad <= starts_bad + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [31:0] w);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic wr_sts(input logic [31:0] w);
    @(negedge clk); sts_we = 1'b1; sts_wdata = w;
    @(negedge clk); sts_we = 1'b0; sts_wdata = '0;
  endtask

  task automatic wait_irq(output int ok);
    int n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    ok = irq ? 1 : 0;
  endtask

  task automatic clear_counts();
    slave_seen = 0; pulses_seen = 0; stops_seen = 0; starts_bad = 0; hi_w = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not end actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ok;
    rst_n = 1'b0; cmd_we = 1'b0; sts_we = 1'b0; cmd_wdata = '0; sts_wdata = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "scl_oe in reset", int'(scl_oe), 0);
    chk("R8", "sda_oe in reset", int'(sda_oe), 0);
    chk("R8", "irq_status in reset", int'(irq_status), 0);
    chk("R8", "cmd_status in reset", int'(cmd_status), 32'h0006_0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2 line levels and busy
    force_scl_low = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "SCL bit after forcing low", int'(cmd_status[18]), 0);
    chk("R2", "busy with SCL low", int'(cmd_status[16]), 1);
    force_scl_low = 1'b0; force_sda_low = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "SCL bit after release", int'(cmd_status[18]), 1);
    chk("R1", "SDA bit after forcing low", int'(cmd_status[17]), 0);
    force_sda_low = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "idle status word", int'(cmd_status), 32'h0006_0000);

    // R3 write without bit 11
    oe_cycles = 0;
    wr_cmd(32'hFFFF_F7FF);
    repeat (60) @(negedge clk);
    chk("R3", "line drive after write without bit 11", oe_cycles, 0);
    chk("R3", "irq after write without bit 11", int'(irq), 0);

    // vector walk: R4 R5 R6 R7
    for (int i = 0; i < 7; i++) begin
      clear_counts();
      slave_k = int'(VEC[i][15:8]);
      wr_cmd(32'h0000_0800);
      @(negedge clk);
      chk("R2", "busy while running", int'(cmd_status[16]), 1);
      wait_irq(ok);
      chk("R7", "done reached", ok, 1);
      chk("R4", $sformatf("pulses k=%0d", slave_k), pulses_seen, int'(VEC[i][7:4]));
      chk("R5", $sformatf("stops k=%0d", slave_k), stops_seen, int'(VEC[i][3:0]));
      chk("R5", "no start condition", starts_bad, 0);
      chk("R7", "irq_status done bit", int'(irq_status), 32'h0000_2000);
      if (VEC[i][3:0] == 0)
        chk("R6", "SDA bit low after failed recovery", int'(cmd_status[17]), 0);
      else
        chk("R4", "SDA bit high after release", int'(cmd_status[17]), 1);
      if (i == 2) chk("R4", "high phase width in cycles", hi_w, TICK_DIV);
      wr_sts(32'h0000_0000);
      chk("R7", "done kept after writing zero", int'(irq), 1);
      wr_sts(32'h0000_2000);
      chk("R7", "done cleared by write-one", int'(irq), 0);
    end

    // R3 second command during a running recovery is ignored
    clear_counts();
    slave_k = 12;
    wr_cmd(32'h0000_0800);
    repeat (30) @(negedge clk);
    wr_cmd(32'h0000_0800);
    wait_irq(ok);
    chk("R3", "pulses with mid-run command", pulses_seen, 8);
    repeat (40) @(negedge clk);
    chk("R3", "no restart after mid-run command", pulses_seen, 8);
    chk("R6", "SDA still low after eight pulses", int'(cmd_status[17]), 0);
    wr_sts(32'h0000_2000);
    chk("R7", "cleared at end", int'(irq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule